// File: doc/BRIEF.md
# Latched Alarm Status and Interrupt Register

This block sits next to a T3/E3 framer and turns its live alarm conditions and frame-boundary pulses into a single status word with an interrupt behind it. The framer supplies already-qualified levels: loss of signal, loss of frame, alarm indication, remote alarm and idle detection. It also supplies single-cycle start-of-frame pulses for the transmit and receive sides. Each source has a latched status bit, and each has a pending-event flag that feeds one interrupt line.

A condition bit latches as soon as its level is seen. Reading the status word clears the bit, but the bit stays set while its condition is still present. The start-of-frame bits latch on their pulse and clear on any read. A pending event is raised when a condition changes state in either direction, or when a start-of-frame pulse arrives. An event reaches the interrupt only if its bit in the mask word is set and the master enable input is high. A read of the status word clears every pending event, except one raised in that same cycle.

The interrupt line is driven by a two-state controller. In IRQ_QUIET the line is low. The controller goes from IRQ_QUIET to IRQ_RAISED on the first clock edge at which an enabled event is pending. It goes back from IRQ_RAISED to IRQ_QUIET on the first edge at which none is pending.

Top module: `alarm_status_irq`

## Requirements
- R1: After reset the status word, the mask word and every pending event are zero, and `irq_o` is low.
- R2: The status word is read at address 0x12, and `rdata` holds the result on the cycle after `rd_en`. Its bit layout is: bit 0 loss of signal, bit 1 loss of frame, bit 2 alarm indication, bit 3 remote alarm, bit 4 idle, bit 5 transmit start-of-frame, bit 6 receive start-of-frame. The input `alarm_i[k]` maps to bit k. A condition bit reads 1 once its condition has been high for one clock edge.
- R3: A status read clears a condition bit whose condition is low during the read, and leaves at 1 a bit whose condition is still high.
- R4: A start-of-frame bit latches on a one-cycle pulse and is cleared by the next status read, whatever the level of its source.
- R5: A condition change in either direction, or a start-of-frame pulse, raises a pending event. With that event enabled, `irq_o` goes high two clock edges after the change.
- R6: `irq_o` stays low unless some pending event has its mask bit at 1 and `master_en_i` is high. Setting the mask bit or the master enable later releases an event that is already pending.
- R7: A status read clears the pending events, and `irq_o` then falls on the second clock edge counted from the read.
- R8: An event in the same cycle as a status read wins. That read returns the old value, the bit stays set, the event stays pending and `irq_o` goes high.
- R9: The mask word is read and written at address 0x13, with bits 6:0 used. Bits 15:7 of any read are zero. Writes to the status address have no effect. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_i | input | 5 | Live conditions: LOS, LOF, AIS, RAI, idle (bit 0 to 4) |
| tx_sof_i | input | 1 | Transmit start-of-frame pulse |
| rx_sof_i | input | 1 | Receive start-of-frame pulse |
| master_en_i | input | 1 | Master-level enable for this register's interrupt |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| irq_o | output | 1 | Active-high interrupt |

## Verification
A table of vectors drives several patterns, each followed by a sequence of reads. These include a single condition that drops before the read, a condition that persists, two conditions at once, and every condition together with only part of them persisting. Each is combined with no start-of-frame pulse, one pulse or both pulses. The pattern of reads tells a sticky bit apart from a one-shot event bit.

Directed tests then cover the interrupt path:
- rising and falling condition edges;
- a pending event released late by the mask or by the master enable;
- a read that coincides with a pulse, which separates "event wins" from "read wins".

Further cases cover mask readback, writes to the status address and reads of an unmapped address.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int N_COND  = 5;
    localparam int N_PULSE = 2;
    localparam int N_BITS  = N_COND + N_PULSE;

    localparam int BIT_TX_SOF = N_COND;
    localparam int BIT_RX_SOF = N_COND + 1;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/alarm_bit_cell.sv
module alarm_bit_cell #(
    parameter bit PERSIST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic clr_i,
    output logic st_o,
    output logic pend_o
);
    logic evt;
    logic st_q;
    logic pend_q;

    generate
        if (PERSIST) begin : g_level
            logic prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= live_i;
            end
            assign evt = live_i ^ prev_q;
        end else begin : g_pulse
            assign evt = live_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= live_i | (st_q & ~clr_i);
            pend_q <= evt | (pend_q & ~clr_i);
        end
    end

    assign st_o   = st_q;
    assign pend_o = pend_q;

    // R2: a present source is latched at the next edge
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_i |=> st_o);
    // R3 / R4: a read with the source absent clears the bit
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !live_i) |=> !st_o);
    // R5: any change raises a pending event
    p_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_o);
    // R7: a read with no new event drops the pending flag
    p_pend_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt) |=> !pend_o);
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import alarm_irq_pkg::*;
#(
    parameter int WIDTH = N_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             master_en_i,
    output logic             irq_o
);
    irq_state_t state_q, state_d;
    logic       armed;

    assign armed = master_en_i & (|(pend_i & mask_i));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (armed)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!armed) state_d = IRQ_QUIET;
            default:                state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R6: master enable low keeps the line low at the next edge
    p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |=> !irq_o);
    // R6: nothing enabled pending keeps the line low at the next edge
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/alarm_status_irq.sv
module alarm_status_irq
    import alarm_irq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h12,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] alarm_i,
    input  logic              tx_sof_i,
    input  logic              rx_sof_i,
    input  logic              master_en_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] USED_MASK = DATA_W'((1 << N_BITS) - 1);

    logic [N_BITS-1:0] live;
    logic [N_BITS-1:0] st;
    logic [N_BITS-1:0] pend;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_status;
    logic              wr_mask;

    assign rd_status = rd_en && (addr == STATUS_ADDR);
    assign wr_mask   = wr_en && (addr == MASK_ADDR);

    assign live[N_COND-1:0] = alarm_i;
    assign live[BIT_TX_SOF] = tx_sof_i;
    assign live[BIT_RX_SOF] = rx_sof_i;

    generate
        for (genvar i = 0; i < N_BITS; i++) begin : g_cell
            alarm_bit_cell #(
                .PERSIST(i < N_COND)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .live_i (live[i]),
                .clr_i  (rd_status),
                .st_o   (st[i]),
                .pend_o (pend[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata & USED_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            if (addr == STATUS_ADDR)    rdata_q <= DATA_W'(st);
            else if (addr == MASK_ADDR) rdata_q <= mask_q;
            else                        rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

    irq_ctrl_fsm #(
        .WIDTH(N_BITS)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .mask_i      (mask_q[N_BITS-1:0]),
        .master_en_i (master_en_i),
        .irq_o       (irq_o)
    );

    // R9: unused upper bits always read zero
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:N_BITS] == '0);
    // R8: an event during a read keeps its status bit
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && tx_sof_i) |=> st[BIT_TX_SOF]);
endmodule

// File: tb/tb_alarm_status_irq.sv
module tb_alarm_status_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  alarm_i = '0;
    logic        tx_sof_i = 1'b0;
    logic        rx_sof_i = 1'b0;
    logic        master_en_i = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alarm_status_irq dut (
        .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .tx_sof_i(tx_sof_i),
        .rx_sof_i(rx_sof_i), .master_en_i(master_en_i), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // fields: cond_on[25:21] sof{rx,tx}[20:19] cond_after[18:14] read1[13:7] read2[6:0]
    localparam logic [25:0] VEC [5] = '{
        {5'b00001, 2'b00, 5'b00000, 7'h01, 7'h00},
        {5'b00010, 2'b01, 5'b00010, 7'h22, 7'h02},
        {5'b10100, 2'b10, 5'b00100, 7'h54, 7'h04},
        {5'b01000, 2'b11, 5'b00000, 7'h68, 7'h00},
        {5'b11111, 2'b00, 5'b10001, 7'h1F, 7'h11}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        rd_en = 1'b1;
        addr = a;
        tick();
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {15'd0, irq_o}, 16'd0);
        rd(8'h12, v); check("R1 status", v, 16'h0000);
        rd(8'h13, v); check("R1 mask", v, 16'h0000);

        // vector table: R2 latch, R3 sticky clear, R4 pulse bits
        for (int i = 0; i < 5; i++) begin
            alarm_i = VEC[i][25:21];
            tx_sof_i = VEC[i][19];
            rx_sof_i = VEC[i][20];
            tick();
            alarm_i = VEC[i][18:14];
            tx_sof_i = 1'b0;
            rx_sof_i = 1'b0;
            tick();
            rd(8'h12, v); check("R2/R4 first read", v, {9'd0, VEC[i][13:7]});
            rd(8'h12, v); check("R3/R4 second read", v, {9'd0, VEC[i][6:0]});
            alarm_i = '0;
            tick();
            rd(8'h12, v); check("R3 read after drop", v, {9'd0, VEC[i][6:0]});
            check("R6 irq masked", {15'd0, irq_o}, 16'd0);
        end
        rd(8'h12, v); check("R3 all clear", v, 16'h0000);

        // R9 register access
        wr(8'h13, 16'hFFFF);
        rd(8'h13, v); check("R9 mask readback", v, 16'h007F);
        wr(8'h12, 16'hFFFF);
        rd(8'h12, v); check("R9 status write ignored", v, 16'h0000);
        rd(8'h00, v); check("R9 unmapped read", v, 16'h0000);
        wr(8'h13, 16'h0001);

        // R6 master enable, R5 rising edge, R7 clear
        alarm_i[0] = 1'b1;
        tick(); tick(); tick();
        check("R6 master off", {15'd0, irq_o}, 16'd0);
        master_en_i = 1'b1;
        tick();
        check("R5 rise irq", {15'd0, irq_o}, 16'd1);
        rd(8'h12, v); check("R2 LOS bit0", v, 16'h0001);
        tick();
        check("R7 irq cleared", {15'd0, irq_o}, 16'd0);

        // R5 falling edge
        alarm_i[0] = 1'b0;
        tick(); tick();
        check("R5 fall irq", {15'd0, irq_o}, 16'd1);
        rd(8'h12, v); check("R3 held while present", v, 16'h0001);
        tick();
        check("R7 irq cleared 2", {15'd0, irq_o}, 16'd0);
        rd(8'h12, v); check("R3 cleared after drop", v, 16'h0000);

        // R6 per-bit mask released late
        alarm_i[1] = 1'b1;
        tick(); tick(); tick();
        check("R6 bit masked", {15'd0, irq_o}, 16'd0);
        wr(8'h13, 16'h0002);
        tick();
        check("R6 mask released", {15'd0, irq_o}, 16'd1);
        rd(8'h12, v); check("R2 LOF bit1", v, 16'h0002);
        tick();
        check("R7 irq cleared 3", {15'd0, irq_o}, 16'd0);

        // R8 event coincident with read
        wr(8'h13, 16'h0020);
        tx_sof_i = 1'b1;
        rd(8'h12, v); check("R8 old value", v, 16'h0002);
        tx_sof_i = 1'b0;
        tick();
        check("R8 irq pending", {15'd0, irq_o}, 16'd1);
        rd(8'h12, v); check("R8 bit kept", v, 16'h0022);
        tick();
        check("R7 irq cleared 4", {15'd0, irq_o}, 16'd0);
        rd(8'h12, v); check("R4 pulse bit cleared", v, 16'h0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule